// File: doc/BRIEF.md
# NOR Flash Buffered Program Sequencer

This block programs a run of 32-bit words into a NOR flash array made of two 16-bit devices side by side on one 32-bit bus. Each command is duplicated into both halves so that both devices receive it. A single start pulse supplies the flash byte address and a byte length. The sequencer then fetches source words from a local word-addressed memory and streams them into the flash through the device's write buffer. It splits the run so that no single buffer load crosses a 64-byte buffer boundary. When the last step is finished, it returns a result word.

For each chunk, the sequencer first acquires the write buffer. It keeps issuing a buffer-write command and a read-status command, then reads the status, until both devices report ready. It then makes one further status read and writes the word count less one. After that come the data words and a confirm command. The sequencer then polls until both devices are ready again. If either device reports a program or erase error, the sequencer stops early. If a device never becomes ready within the poll limit, the run ends with a timeout result. Every run closes with a clear-status command and a read-array command, so the flash is left readable.

The controller has fifteen states. IDLE goes to CLR0 on start. CLR0 goes to FIN_CLR when the rounded length is zero and to ACQ_BUF otherwise. The acquire loop runs ACQ_BUF, ACQ_RSR, ACQ_RD, ACQ_CHK. ACQ_CHK goes to EXTRA_RD when both devices are ready, back to ACQ_BUF when they are not, and to FIN_CLR on timeout. The load path runs EXTRA_RD, CNT, DATA. DATA repeats until the chunk's last word and then goes to CONFIRM. The completion loop runs CONFIRM, POLL_RD, POLL_CHK. POLL_CHK goes back to POLL_RD when the devices are not ready. It goes to ACQ_BUF when they are ready with no error and words remain. It goes to FIN_CLR on error, on timeout, or when no words remain. The close runs FIN_CLR, FIN_RA, DONE, and DONE returns to IDLE.

Top module: `nor_bufprog_seq`

## Requirements
- R1: After reset, busy_o and done_o are 0 and no flash request is issued.
- R2: The first flash transaction of a run writes 0x00500050 (clear status) at the start address with bits 1:0 forced to zero.
- R3: The byte length is rounded up to a multiple of 64, and exactly that many bytes divided by 4 data words are written. A length of 0 writes no data words and no buffer commands.
- R4: Each chunk's word count is the smaller of the remaining words and (64 minus the address bits 5:0) divided by 4. The count minus one is written in both bits 15:0 and bits 31:16, at the chunk's first address.
- R5: Per chunk, the sequencer writes 0x00E800E8, then 0x00700070, then reads status at the chunk address. It repeats this triple until status AND 0x00800080 equals 0x00800080. It then does one more status read before the count write.
- R6: Data words come from source word 0 onward, in order, and go to consecutive flash word addresses. Each source read is issued exactly one cycle before its flash write. The data words are followed by 0x00D000D0 (confirm) at the next word address.
- R7: After confirm, status is read at that address until the ready mask is set. A nonzero status AND 0x00300030 (bits 5:4 of either half) ends programming with no further chunk.
- R8: Every run ends with 0x00500050 and then 0x00FF00FF at the current address, followed by done_o high for exactly one cycle.
- R9: result_o is 0 on success. On a device error it is the current address minus the start address plus one, where the current address is the one holding the confirm command.
- R10: If POLL_LIMIT consecutive status checks within one wait find the device not ready, result_o is 0xFFFFFFFF and the close sequence of R8 follows.
- R11: busy_o is high from the cycle after an accepted start through the done cycle. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| start_addr_i | input | ADDR_W | Flash byte address of the first word |
| len_i | input | LEN_W | Byte length to program |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| result_o | output | ADDR_W | 0, error offset plus one, or all ones on timeout |
| src_rd_o | output | 1 | Source memory read strobe |
| src_addr_o | output | SRC_AW | Source word address |
| src_data_i | input | 32 | Source word, valid one cycle after the read |
| fl_req_o | output | 1 | Flash transaction this cycle |
| fl_we_o | output | 1 | 1 for write, 0 for read |
| fl_addr_o | output | ADDR_W | Flash byte address |
| fl_wdata_o | output | 32 | Flash write data or command |
| fl_rdata_i | input | 32 | Flash read data, valid one cycle after the read |

## Verification
On every cycle, the assertions check several properties. Each source read is followed by a flash write, and each flash request falls inside a busy period. Done is a single-cycle pulse that ends busy. Each run opens with clear status at the sampled address, and all flash addresses are word aligned. Only the bench scenarios can show the rest, because a cycle-local property cannot see the whole transaction order. This covers chunk splitting at unaligned starts, the count encoding, the acquire retries, stopping on a device error, the error and timeout result values, the zero-length run, and a start pulse ignored mid-run.

// File: rtl/nbp_pkg.sv
package nbp_pkg;

    localparam logic [31:0] CMD_CLR_STATUS  = 32'h0050_0050;
    localparam logic [31:0] CMD_BUF_WRITE   = 32'h00E8_00E8;
    localparam logic [31:0] CMD_READ_STATUS = 32'h0070_0070;
    localparam logic [31:0] CMD_CONFIRM     = 32'h00D0_00D0;
    localparam logic [31:0] CMD_READ_ARRAY  = 32'h00FF_00FF;
    localparam logic [31:0] MASK_READY      = 32'h0080_0080;
    localparam logic [31:0] MASK_ERROR      = 32'h0030_0030;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CLR0,
        S_ACQ_BUF,
        S_ACQ_RSR,
        S_ACQ_RD,
        S_ACQ_CHK,
        S_EXTRA_RD,
        S_CNT,
        S_DATA,
        S_CONFIRM,
        S_POLL_RD,
        S_POLL_CHK,
        S_FIN_CLR,
        S_FIN_RA,
        S_DONE
    } seq_state_e;

endpackage

// File: rtl/nbp_chunk_calc.sv
module nbp_chunk_calc #(
    parameter int BUF_BYTES = 64,
    parameter int WC_W      = 15,
    localparam int OFF_W    = $clog2(BUF_BYTES),
    localparam int BUF_WORDS = BUF_BYTES / 4
) (
    input  logic [OFF_W-3:0] word_off,
    input  logic [WC_W-1:0]  words_left,
    output logic [WC_W-1:0]  count,
    output logic [31:0]      count_word
);

    logic [WC_W-1:0] room;
    logic [WC_W-1:0] cnt_m1;

    always_comb begin
        room       = WC_W'(BUF_WORDS) - WC_W'(word_off);
        count      = (words_left < room) ? words_left : room;
        cnt_m1     = count - WC_W'(1);
        count_word = {16'(cnt_m1), 16'(cnt_m1)};
    end

endmodule

// File: rtl/nbp_poll_timer.sv
module nbp_poll_timer #(
    parameter int LIMIT = 1024,
    localparam int TW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic last
);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick && !last) begin
            cnt <= cnt + TW'(1);
        end
    end

    assign last = (cnt == TW'(LIMIT - 1));

endmodule

// File: rtl/nor_bufprog_seq.sv
module nor_bufprog_seq
    import nbp_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SRC_AW     = 16,
    parameter int LEN_W      = 16,
    parameter int BUF_BYTES  = 64,
    parameter int POLL_LIMIT = 1024,
    localparam int WC_W      = LEN_W - 1,
    localparam int OFF_W     = $clog2(BUF_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] result_o,
    output logic              src_rd_o,
    output logic [SRC_AW-1:0] src_addr_o,
    input  logic [31:0]       src_data_i,
    output logic              fl_req_o,
    output logic              fl_we_o,
    output logic [ADDR_W-1:0] fl_addr_o,
    output logic [31:0]       fl_wdata_o,
    input  logic [31:0]       fl_rdata_i
);

    seq_state_e state, nxt;

    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] base_addr;
    logic [WC_W-1:0]   words_left;
    logic [WC_W-1:0]   chunk_left;
    logic [SRC_AW-1:0] src_ptr;
    logic [ADDR_W-1:0] result_q;

    logic [LEN_W:0]    len_round;
    logic [WC_W-1:0]   len_words;
    logic [WC_W-1:0]   chunk_cnt;
    logic [31:0]       chunk_word;
    logic              dev_ready;
    logic              dev_error;
    logic              tmr_clr;
    logic              tmr_tick;
    logic              tmr_last;

    // length rounding to whole buffers, then bytes to words
    always_comb begin
        len_round = ({1'b0, len_i} + (LEN_W+1)'(BUF_BYTES - 1))
                    & ~((LEN_W+1)'(BUF_BYTES - 1));
        len_words = len_round[LEN_W:2];
    end

    assign dev_ready = ((fl_rdata_i & MASK_READY) == MASK_READY);
    assign dev_error = |(fl_rdata_i & MASK_ERROR);

    nbp_chunk_calc #(
        .BUF_BYTES (BUF_BYTES),
        .WC_W      (WC_W)
    ) u_chunk (
        .word_off   (cur_addr[OFF_W-1:2]),
        .words_left (words_left),
        .count      (chunk_cnt),
        .count_word (chunk_word)
    );

    assign tmr_clr  = (state == S_CLR0) || (state == S_CONFIRM)
                   || ((state == S_POLL_CHK) && dev_ready);
    assign tmr_tick = ((state == S_ACQ_CHK) || (state == S_POLL_CHK)) && !dev_ready;

    nbp_poll_timer #(
        .LIMIT (POLL_LIMIT)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .tick  (tmr_tick),
        .last  (tmr_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:     if (start_i) nxt = S_CLR0;
            S_CLR0:     nxt = (words_left == '0) ? S_FIN_CLR : S_ACQ_BUF;
            S_ACQ_BUF:  nxt = S_ACQ_RSR;
            S_ACQ_RSR:  nxt = S_ACQ_RD;
            S_ACQ_RD:   nxt = S_ACQ_CHK;
            S_ACQ_CHK: begin
                if (dev_ready)     nxt = S_EXTRA_RD;
                else if (tmr_last) nxt = S_FIN_CLR;
                else               nxt = S_ACQ_BUF;
            end
            S_EXTRA_RD: nxt = S_CNT;
            S_CNT:      nxt = S_DATA;
            S_DATA:     if (chunk_left == WC_W'(1)) nxt = S_CONFIRM;
            S_CONFIRM:  nxt = S_POLL_RD;
            S_POLL_RD:  nxt = S_POLL_CHK;
            S_POLL_CHK: begin
                if (dev_ready) begin
                    if (dev_error || (words_left == '0)) nxt = S_FIN_CLR;
                    else                                 nxt = S_ACQ_BUF;
                end else if (tmr_last) begin
                    nxt = S_FIN_CLR;
                end else begin
                    nxt = S_POLL_RD;
                end
            end
            S_FIN_CLR:  nxt = S_FIN_RA;
            S_FIN_RA:   nxt = S_DONE;
            S_DONE:     nxt = S_IDLE;
            default:    nxt = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr   <= '0;
            base_addr  <= '0;
            words_left <= '0;
            chunk_left <= '0;
            src_ptr    <= '0;
            result_q   <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start_i) begin
                        base_addr  <= start_addr_i & ~ADDR_W'(3);
                        cur_addr   <= start_addr_i & ~ADDR_W'(3);
                        words_left <= len_words;
                        src_ptr    <= '0;
                        result_q   <= '0;
                    end
                end
                S_ACQ_CHK: begin
                    if (!dev_ready && tmr_last) result_q <= '1;
                end
                S_CNT: begin
                    chunk_left <= chunk_cnt;
                    words_left <= words_left - chunk_cnt;
                    src_ptr    <= src_ptr + SRC_AW'(1);
                end
                S_DATA: begin
                    cur_addr   <= cur_addr + ADDR_W'(4);
                    chunk_left <= chunk_left - WC_W'(1);
                    if (chunk_left > WC_W'(1)) src_ptr <= src_ptr + SRC_AW'(1);
                end
                S_POLL_CHK: begin
                    if (dev_ready && dev_error)
                        result_q <= cur_addr - base_addr + ADDR_W'(1);
                    else if (!dev_ready && tmr_last)
                        result_q <= '1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        fl_req_o   = 1'b0;
        fl_we_o    = 1'b0;
        fl_addr_o  = cur_addr;
        fl_wdata_o = '0;
        src_rd_o   = 1'b0;
        src_addr_o = src_ptr;
        done_o     = 1'b0;
        unique case (state)
            S_CLR0, S_FIN_CLR: begin
                fl_req_o = 1'b1; fl_we_o = 1'b1; fl_wdata_o = CMD_CLR_STATUS;
            end
            S_ACQ_BUF: begin
                fl_req_o = 1'b1; fl_we_o = 1'b1; fl_wdata_o = CMD_BUF_WRITE;
            end
            S_ACQ_RSR: begin
                fl_req_o = 1'b1; fl_we_o = 1'b1; fl_wdata_o = CMD_READ_STATUS;
            end
            S_ACQ_RD, S_EXTRA_RD, S_POLL_RD: begin
                fl_req_o = 1'b1;
            end
            S_CNT: begin
                fl_req_o = 1'b1; fl_we_o = 1'b1; fl_wdata_o = chunk_word;
                src_rd_o = 1'b1;
            end
            S_DATA: begin
                fl_req_o = 1'b1; fl_we_o = 1'b1; fl_wdata_o = src_data_i;
                src_rd_o = (chunk_left > WC_W'(1));
            end
            S_CONFIRM: begin
                fl_req_o = 1'b1; fl_we_o = 1'b1; fl_wdata_o = CMD_CONFIRM;
            end
            S_FIN_RA: begin
                fl_req_o = 1'b1; fl_we_o = 1'b1; fl_wdata_o = CMD_READ_ARRAY;
            end
            S_DONE: done_o = 1'b1;
            default: ;
        endcase
    end

    assign busy_o   = (state != S_IDLE);
    assign result_o = result_q;

endmodule

// File: rtl/nbp_seq_chk.sv
module nbp_seq_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] start_addr_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              src_rd_o,
    input logic              fl_req_o,
    input logic              fl_we_o,
    input logic [ADDR_W-1:0] fl_addr_o,
    input logic [31:0]       fl_wdata_o
);

    // R6
    prefetch_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_rd_o |=> (fl_req_o && fl_we_o));

    // R6
    word_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req_o |-> (fl_addr_o[1:0] == 2'b00));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(done_o));

    // R1
    req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req_o |-> busy_o);

    // R2
    open_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (fl_req_o && fl_we_o && fl_wdata_o == 32'h0050_0050
                           && fl_addr_o == ($past(start_addr_i) & ~ADDR_W'(3))));

endmodule

bind nor_bufprog_seq nbp_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_addr_i (start_addr_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .src_rd_o     (src_rd_o),
    .fl_req_o     (fl_req_o),
    .fl_we_o      (fl_we_o),
    .fl_addr_o    (fl_addr_o),
    .fl_wdata_o   (fl_wdata_o)
);

// File: tb/tb_nor_bufprog_seq.sv
`timescale 1ns/100ps
module tb_nor_bufprog_seq;

    localparam int LIM = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] start_addr_i = '0;
    logic [15:0] len_i = '0;
    logic        busy_o, done_o;
    logic [31:0] result_o;
    logic        src_rd_o;
    logic [15:0] src_addr_o;
    logic [31:0] src_data_i = '0;
    logic        fl_req_o, fl_we_o;
    logic [31:0] fl_addr_o, fl_wdata_o;
    logic [31:0] fl_rdata_i = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    nor_bufprog_seq #(.POLL_LIMIT(LIM)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .len_i(len_i), .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
        .src_rd_o(src_rd_o), .src_addr_o(src_addr_o), .src_data_i(src_data_i),
        .fl_req_o(fl_req_o), .fl_we_o(fl_we_o), .fl_addr_o(fl_addr_o),
        .fl_wdata_o(fl_wdata_o), .fl_rdata_i(fl_rdata_i)
    );

    // source memory: one-cycle read latency
    always @(posedge clk) if (src_rd_o) src_data_i <= 32'hC0DE_0000 | 32'(src_addr_o);

    // flash model
    int cfg_acq = 0, cfg_prog = 0, cfg_err = -1;
    int acq_left = 0, prog_left = 0, chunk_idx = 0;
    int mode = 0;
    always @(posedge clk) begin
        if (start_i && !busy_o) begin
            acq_left <= cfg_acq; prog_left <= cfg_prog; chunk_idx <= 0; mode <= 0;
        end else if (fl_req_o) begin
            if (fl_we_o) begin
                if (fl_wdata_o == 32'h00E8_00E8) mode <= 1;
                else if (fl_wdata_o == 32'h00D0_00D0) begin
                    mode <= 2; chunk_idx <= chunk_idx + 1;
                end else if (fl_wdata_o == 32'h0050_0050 || fl_wdata_o == 32'h00FF_00FF) mode <= 0;
            end else begin
                if (mode == 1) begin
                    if (acq_left > 0) begin acq_left <= acq_left - 1; fl_rdata_i <= 32'h0000_0080; end
                    else fl_rdata_i <= 32'h0080_0080;
                end else if (mode == 2) begin
                    if (prog_left > 0) begin prog_left <= prog_left - 1; fl_rdata_i <= 32'h0080_0000; end
                    else fl_rdata_i <= 32'h0080_0080 | ((chunk_idx - 1 == cfg_err) ? 32'h0020_0000 : 32'h0);
                end else fl_rdata_i <= 32'h0;
            end
        end
    end

    // scoreboard queues
    bit          q_we[$];
    logic [31:0] q_addr[$];
    logic [31:0] q_data[$];
    string       q_tag[$];
    logic [31:0] r_exp[$];

    task automatic push_exp(input bit we, input logic [31:0] a, input logic [31:0] d, input string tag);
        q_we.push_back(we); q_addr.push_back(a); q_data.push_back(d); q_tag.push_back(tag);
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (fl_req_o) begin
                if (q_we.size() == 0) begin
                    check(0, "R3 unexpected flash transaction", fl_addr_o, 32'hX);
                end else begin
                    bit w; logic [31:0] a, d; string t;
                    w = q_we.pop_front(); a = q_addr.pop_front();
                    d = q_data.pop_front(); t = q_tag.pop_front();
                    check(fl_we_o == w, {t, " direction"}, 32'(fl_we_o), 32'(w));
                    check(fl_addr_o == a, {t, " address"}, fl_addr_o, a);
                    if (w) check(fl_wdata_o == d, {t, " data"}, fl_wdata_o, d);
                end
            end
            if (done_o) begin
                if (r_exp.size() == 0) check(0, "R8 unexpected done", 32'd1, 32'd0);
                else begin
                    logic [31:0] e;
                    e = r_exp.pop_front();
                    check(result_o == e, "R9 R10 result", result_o, e);
                end
            end
        end
    end

    // driver: builds the expected transaction list, then runs the block
    task automatic run_case(input logic [31:0] sa, input int len, input int acqw,
                            input int progw, input int errc, input bit tmo, input bit poke);
        logic [31:0] p, res;
        int words, src, chunk, acq, prog, room, cnt;
        bit stop, rdy;
        p = sa & ~32'd3;
        push_exp(1, p, 32'h0050_0050, "R2 opening clear");
        words = ((len + 63) / 64) * 16;
        src = 0; chunk = 0; acq = acqw; prog = progw; res = 0; stop = 0;
        while (words > 0 && !stop) begin
            do begin
                push_exp(1, p, 32'h00E8_00E8, "R5 buffer command");
                push_exp(1, p, 32'h0070_0070, "R5 status command");
                push_exp(0, p, 0, "R5 status read");
                rdy = (acq == 0);
                if (!rdy) acq--;
            end while (!rdy);
            push_exp(0, p, 0, "R5 extra read");
            room = (64 - int'(p & 32'd63)) / 4;
            cnt = (words < room) ? words : room;
            push_exp(1, p, {16'(cnt - 1), 16'(cnt - 1)}, "R4 count word");
            for (int i = 0; i < cnt; i++) begin
                push_exp(1, p, 32'hC0DE_0000 | 32'(src), "R6 data word");
                p += 4; src++;
            end
            push_exp(1, p, 32'h00D0_00D0, "R6 confirm");
            words -= cnt;
            if (tmo) begin
                for (int i = 0; i < LIM; i++) push_exp(0, p, 0, "R10 poll read");
                res = '1; stop = 1;
            end else begin
                for (int i = 0; i <= prog; i++) push_exp(0, p, 0, "R7 poll read");
                prog = 0;
                if (chunk == errc) begin res = p - (sa & ~32'd3) + 1; stop = 1; end
                chunk++;
            end
        end
        push_exp(1, p, 32'h0050_0050, "R8 closing clear");
        push_exp(1, p, 32'h00FF_00FF, "R8 read array");
        r_exp.push_back(res);

        cfg_acq = acqw; cfg_prog = tmo ? 1000 : progw; cfg_err = errc;
        @(posedge clk); #1;
        start_i = 1; start_addr_i = sa; len_i = 16'(len);
        @(posedge clk); #1;
        start_i = 0;
        check(busy_o == 1'b1, "R11 busy after start", 32'(busy_o), 32'd1);
        if (poke) begin
            repeat (6) @(posedge clk);
            #1; start_i = 1; start_addr_i = 32'h0000_7000; len_i = 16'd256;
            @(posedge clk); #1; start_i = 0;
        end
        while (busy_o) begin @(posedge clk); #1; end
        check(q_we.size() == 0, "R3 all transactions seen", 32'(q_we.size()), 32'd0);
        check(r_exp.size() == 0, "R8 done seen", 32'(r_exp.size()), 32'd0);
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(busy_o == 0, "R1 reset busy", 32'(busy_o), 0);
        check(done_o == 0, "R1 reset done", 32'(done_o), 0);
        check(fl_req_o == 0, "R1 reset request", 32'(fl_req_o), 0);
        rst_n = 1;
        repeat (2) @(posedge clk);
        // aligned single chunk
        run_case(32'h0000_1000, 64, 0, 0, -1, 0, 0);
        // unaligned split, acquire retries, start ignored while busy (R11)
        run_case(32'h0000_2020, 50, 2, 3, -1, 0, 1);
        // zero length (R3)
        run_case(32'h0000_2400, 0, 0, 0, -1, 0, 0);
        // four chunks with device error on the second (R7, R9)
        run_case(32'h0000_3004, 130, 1, 2, 1, 0, 0);
        // poll timeout (R10)
        run_case(32'h0000_5000, 64, 0, 0, -1, 1, 0);
        // small length rounds up (R3)
        run_case(32'h0000_0042, 1, 0, 1, -1, 0, 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL R11 watchdog actual busy expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule